// File: doc/BRIEF.md
# Two-Pipe Priority Layer Compositor

This block merges four rectangular layers into one RGB pixel stream, driven by a raster x/y counter. Every layer is placed on one of two pipes. Each pipe first keeps only the highest-priority layer that covers the current coordinate. The winning pixel of the upper pipe (pipe 1) is then alpha-blended over the winning pixel of the lower pipe (pipe 0). Alpha is applied only between the two pipe results. Layers on the same pipe never blend with each other.

The caller supplies one ARGB8888 pixel per layer for the current coordinate, together with static layer geometry and attributes. It receives the composed pixel two cycles later. A defect mode can be switched on for compatibility. In that mode, a translucent priority-0 winner on pipe 0 loses its pixel data and shows the background colour instead.

Top module: `dual_pipe_compositor`

## Requirements
- R1: While reset is asserted, and until new results emerge from the pipeline, `outRgb` is 0 (black).
- R2: Layer l covers (x,y) only when all of these hold: its enable bit is set; x < display width and y < display height; layerX ≤ x < layerX+layerW; layerY ≤ y < layerY+layerH. Coordinates outside the display therefore show the background.
- R3: Within a pipe, the covering layer with the numerically largest 2-bit priority wins. On equal priority, the lower layer index wins. A layer's `layerPipe` bit (0 or 1) selects its pipe.
- R4: A pipe with no covering layer yields the background colour `bgColor` with alpha 0. The output then equals the pipe 0 result.
- R5: For each 8-bit channel, out = (a*p1 + (255-a)*p0 + 127) / 255, using integer division. Here a is the effective alpha of the pipe 1 winner, p1 is its channel value, and p0 is the pipe 0 channel value. Pixels are packed A[31:24] R[23:16] G[15:8] B[7:0]. `outRgb` is R[23:16] G[15:8] B[7:0].
- R6: When a layer's global-alpha enable is set, its 8-bit global alpha replaces the per-pixel alpha as its effective alpha.
- R7: When `defectMode` is 1 and the pipe 0 winner has priority 0 and effective alpha other than 255, pipe 0 yields `bgColor`. With `defectMode` 0, or with an opaque winner, the winner's pixel is kept.
- R8: The result for inputs applied before clock edge k appears on `outRgb` after edge k+1. This is a latency of two registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rasterX | input | COORD_W | Current column |
| rasterY | input | COORD_W | Current row |
| dispW | input | COORD_W | Display width in pixels |
| dispH | input | COORD_W | Display height in pixels |
| layerEn | input | 4 | Per-layer enable |
| layerPipe | input | 4 | Per-layer pipe select |
| layerPrio | input | 8 | 2-bit priority per layer, layer l at [2l+1:2l] |
| layerX | input | 4*COORD_W | Left edge per layer |
| layerY | input | 4*COORD_W | Top edge per layer |
| layerW | input | 4*COORD_W | Width per layer |
| layerH | input | 4*COORD_W | Height per layer |
| layerGaEn | input | 4 | Global-alpha enable per layer |
| layerGa | input | 32 | 8-bit global alpha per layer |
| layerPix | input | 128 | ARGB8888 pixel per layer, layer l at [32l+31:32l] |
| bgColor | input | 24 | Background RGB |
| defectMode | input | 1 | Enables the priority-0 alpha defect |
| outRgb | output | 24 | Composed RGB pixel |

## Verification
A wrong pipe winner or a wrong coverage decision shows up as a wrong colour at the affected coordinate, exactly two cycles after that coordinate is presented. Sweeping the raster across overlapping rectangles and the display border exposes such faults at the first mismatching pixel. Blend errors usually surface at particular alpha values, such as 0, 255 or mid-range. For that reason the per-pixel alpha varies continuously across the sweep, and every pixel is compared against a behavioural model.

// File: rtl/dpc_pkg.sv
package dpc_pkg;
  localparam int LAYERS = 4;
  localparam int PIPES  = 2;
  localparam int LIDX_W = $clog2(LAYERS);
  localparam int PRIO_W = 2;

  typedef struct packed {
    logic [PIPES-1:0]             hit;
    logic [PIPES-1:0][LIDX_W-1:0] sel;
    logic                         dropLow;
  } pickStrobe_t;

  function automatic logic [7:0] effAlpha(input logic gaEn, input logic [7:0] ga,
                                          input logic [7:0] pa);
    return gaEn ? ga : pa;
  endfunction
endpackage

// File: rtl/dpc_ctrl.sv
module dpc_ctrl
  import dpc_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [COORD_W-1:0]          rasterX,
  input  logic [COORD_W-1:0]          rasterY,
  input  logic [COORD_W-1:0]          dispW,
  input  logic [COORD_W-1:0]          dispH,
  input  logic [LAYERS-1:0]           layerEn,
  input  logic [LAYERS-1:0]           layerPipe,
  input  logic [LAYERS*PRIO_W-1:0]    layerPrio,
  input  logic [LAYERS*COORD_W-1:0]   layerX,
  input  logic [LAYERS*COORD_W-1:0]   layerY,
  input  logic [LAYERS*COORD_W-1:0]   layerW,
  input  logic [LAYERS*COORD_W-1:0]   layerH,
  input  logic [LAYERS-1:0]           layerGaEn,
  input  logic [LAYERS*8-1:0]         layerGa,
  input  logic [LAYERS*8-1:0]         pixAlpha,
  input  logic                        defectMode,
  output pickStrobe_t                 strobe
);
  localparam int EXT_W = COORD_W + 1;

  logic [LAYERS-1:0]       covers;
  logic [PRIO_W-1:0]       prio [LAYERS];
  logic [7:0]              alphaEff [LAYERS];
  logic                    pipeHit [PIPES];
  logic [LIDX_W-1:0]       pipeSel [PIPES];
  logic                    inDisp;

  assign inDisp = (rasterX < dispW) && (rasterY < dispH);

  genvar l, p;
  generate
    for (l = 0; l < LAYERS; l++) begin : g_layer
      logic [COORD_W-1:0] lx, ly, lw, lh;
      assign lx = layerX[l*COORD_W +: COORD_W];
      assign ly = layerY[l*COORD_W +: COORD_W];
      assign lw = layerW[l*COORD_W +: COORD_W];
      assign lh = layerH[l*COORD_W +: COORD_W];
      assign prio[l] = layerPrio[l*PRIO_W +: PRIO_W];
      assign alphaEff[l] = effAlpha(layerGaEn[l], layerGa[l*8 +: 8], pixAlpha[l*8 +: 8]);
      assign covers[l] = layerEn[l] && inDisp
                       && (rasterX >= lx) && (EXT_W'(rasterX) < EXT_W'(lx) + EXT_W'(lw))
                       && (rasterY >= ly) && (EXT_W'(rasterY) < EXT_W'(ly) + EXT_W'(lh));
    end

    for (p = 0; p < PIPES; p++) begin : g_pipe
      logic              found;
      logic [LIDX_W-1:0] idx;
      logic [PRIO_W-1:0] best;
      always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < LAYERS; i++) begin
          if (covers[i] && (layerPipe[i] == 1'(p)) && (!found || prio[i] > best)) begin
            found = 1'b1;
            idx   = LIDX_W'(i);
            best  = prio[i];
          end
        end
      end
      assign pipeHit[p] = found;
      assign pipeSel[p] = idx;
      assign strobe.hit[p] = found;
      assign strobe.sel[p] = idx;

      // R2
      sel_covers_chk: assert property (@(posedge clk) disable iff (!rstN)
        pipeHit[p] |-> (covers[pipeSel[p]] && layerPipe[pipeSel[p]] == 1'(p)));

      for (l = 0; l < LAYERS; l++) begin : g_win
        // R3
        prio_win_chk: assert property (@(posedge clk) disable iff (!rstN)
          (covers[l] && layerPipe[l] == 1'(p)) |-> (pipeHit[p] && prio[pipeSel[p]] >= prio[l]));
      end
    end
  endgenerate

  assign strobe.dropLow = defectMode && pipeHit[0] && (prio[pipeSel[0]] == '0)
                        && (alphaEff[pipeSel[0]] != 8'hFF);

  // R7
  drop_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.dropLow |-> (defectMode && pipeHit[0] && prio[pipeSel[0]] == '0));
endmodule

// File: rtl/dpc_datapath.sv
module dpc_datapath
  import dpc_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  pickStrobe_t        strobe,
  input  logic [LAYERS*32-1:0] layerPix,
  input  logic [LAYERS-1:0]  layerGaEn,
  input  logic [LAYERS*8-1:0] layerGa,
  input  logic [23:0]        bgColor,
  output logic [23:0]        outRgb
);
  logic [31:0] pix [LAYERS];
  logic [7:0]  alphaEff [LAYERS];

  genvar l;
  generate
    for (l = 0; l < LAYERS; l++) begin : g_px
      assign pix[l] = layerPix[l*32 +: 32];
      assign alphaEff[l] = effAlpha(layerGaEn[l], layerGa[l*8 +: 8], pix[l][31:24]);
    end
  endgenerate

  // stage 1: pipe results
  logic [23:0] p0Rgb, p1Rgb;
  logic [7:0]  p1A;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      p0Rgb <= '0;
      p1Rgb <= '0;
      p1A   <= '0;
    end else begin
      p0Rgb <= (strobe.hit[0] && !strobe.dropLow) ? pix[strobe.sel[0]][23:0] : bgColor;
      p1Rgb <= strobe.hit[1] ? pix[strobe.sel[1]][23:0] : bgColor;
      p1A   <= strobe.hit[1] ? alphaEff[strobe.sel[1]] : 8'h00;
    end
  end

  // stage 2: blend
  logic [23:0] blendRgb;
  always_comb begin
    for (int c = 0; c < 3; c++) begin
      logic [15:0] num;
      num = 16'(p1A) * 16'(p1Rgb[c*8 +: 8])
          + 16'(8'hFF - p1A) * 16'(p0Rgb[c*8 +: 8]) + 16'd127;
      blendRgb[c*8 +: 8] = 8'(num / 16'd255);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) outRgb <= '0;
    else       outRgb <= blendRgb;
  end

  // R4
  clear_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (p1A == 8'h00) |=> (outRgb == $past(p0Rgb)));

  // R5
  opaque_top_chk: assert property (@(posedge clk) disable iff (!rstN)
    (p1A == 8'hFF) |=> (outRgb == $past(p1Rgb)));
endmodule

// File: rtl/dual_pipe_compositor.sv
module dual_pipe_compositor
  import dpc_pkg::*;
#(
  parameter int COORD_W = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [COORD_W-1:0]          rasterX,
  input  logic [COORD_W-1:0]          rasterY,
  input  logic [COORD_W-1:0]          dispW,
  input  logic [COORD_W-1:0]          dispH,
  input  logic [LAYERS-1:0]           layerEn,
  input  logic [LAYERS-1:0]           layerPipe,
  input  logic [LAYERS*PRIO_W-1:0]    layerPrio,
  input  logic [LAYERS*COORD_W-1:0]   layerX,
  input  logic [LAYERS*COORD_W-1:0]   layerY,
  input  logic [LAYERS*COORD_W-1:0]   layerW,
  input  logic [LAYERS*COORD_W-1:0]   layerH,
  input  logic [LAYERS-1:0]           layerGaEn,
  input  logic [LAYERS*8-1:0]         layerGa,
  input  logic [LAYERS*32-1:0]        layerPix,
  input  logic [23:0]                 bgColor,
  input  logic                        defectMode,
  output logic [23:0]                 outRgb
);
  pickStrobe_t strobe;
  logic [LAYERS*8-1:0] pixAlpha;

  genvar l;
  generate
    for (l = 0; l < LAYERS; l++) begin : g_a
      assign pixAlpha[l*8 +: 8] = layerPix[l*32+24 +: 8];
    end
  endgenerate

  dpc_ctrl #(.COORD_W(COORD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rasterX(rasterX), .rasterY(rasterY),
    .dispW(dispW), .dispH(dispH), .layerEn(layerEn), .layerPipe(layerPipe),
    .layerPrio(layerPrio), .layerX(layerX), .layerY(layerY), .layerW(layerW),
    .layerH(layerH), .layerGaEn(layerGaEn), .layerGa(layerGa),
    .pixAlpha(pixAlpha), .defectMode(defectMode), .strobe(strobe)
  );

  dpc_datapath u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .layerPix(layerPix),
    .layerGaEn(layerGaEn), .layerGa(layerGa), .bgColor(bgColor), .outRgb(outRgb)
  );
endmodule

// File: tb/sim_dual_pipe_compositor.sv
`timescale 1ns/1ps
module sim_dual_pipe_compositor;
  localparam int CW = 12;
  localparam int NL = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [CW-1:0] rasterX = '0, rasterY = '0, dispW = '0, dispH = '0;
  logic [NL-1:0] layerEn = '0, layerPipe = '0, layerGaEn = '0;
  logic [NL*2-1:0] layerPrio = '0;
  logic [NL*CW-1:0] layerX = '0, layerY = '0, layerW = '0, layerH = '0;
  logic [NL*8-1:0] layerGa = '0;
  logic [NL*32-1:0] layerPix = '0;
  logic [23:0] bgColor = '0;
  logic defectMode = 1'b0;
  logic [23:0] outRgb;
  logic [NL-1:0] opaque = '0;

  int vecCnt = 0;
  int errCnt = 0;
  logic [23:0] expQ[$];
  string tagQ[$];

  always #10 clk = ~clk;

  dual_pipe_compositor #(.COORD_W(CW)) u0 (
    .clk(clk), .rstN(rstN), .rasterX(rasterX), .rasterY(rasterY), .dispW(dispW),
    .dispH(dispH), .layerEn(layerEn), .layerPipe(layerPipe), .layerPrio(layerPrio),
    .layerX(layerX), .layerY(layerY), .layerW(layerW), .layerH(layerH),
    .layerGaEn(layerGaEn), .layerGa(layerGa), .layerPix(layerPix),
    .bgColor(bgColor), .defectMode(defectMode), .outRgb(outRgb)
  );

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: outRgb=%06h expected=%06h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic setLayer(int l, bit en, bit pipe, int prio, int x, int y, int w, int h,
                          bit gaEn, int ga, bit opq);
    layerEn[l] = en;
    layerPipe[l] = pipe;
    layerPrio[l*2 +: 2] = 2'(prio);
    layerX[l*CW +: CW] = CW'(x);
    layerY[l*CW +: CW] = CW'(y);
    layerW[l*CW +: CW] = CW'(w);
    layerH[l*CW +: CW] = CW'(h);
    layerGaEn[l] = gaEn;
    layerGa[l*8 +: 8] = 8'(ga);
    opaque[l] = opq;
  endtask

  function automatic int effA(int l);
    if (layerGaEn[l]) return int'(layerGa[l*8 +: 8]);
    return int'(layerPix[l*32+24 +: 8]);
  endfunction

  function automatic logic [23:0] model(int x, int y);
    int win[2];
    int wp[2];
    int a;
    logic [23:0] c0, c1, r;
    win[0] = -1; win[1] = -1; wp[0] = 0; wp[1] = 0;
    for (int l = NL - 1; l >= 0; l--) begin
      int lx = int'(layerX[l*CW +: CW]);
      int ly = int'(layerY[l*CW +: CW]);
      int pr = int'(layerPrio[l*2 +: 2]);
      int pp = int'(layerPipe[l]);
      if (layerEn[l] && x < int'(dispW) && y < int'(dispH) && x >= lx && y >= ly &&
          x < lx + int'(layerW[l*CW +: CW]) && y < ly + int'(layerH[l*CW +: CW]))
        if (win[pp] < 0 || pr >= wp[pp]) begin
          win[pp] = l;
          wp[pp] = pr;
        end
    end
    if (win[0] < 0) c0 = bgColor;
    else if (defectMode && wp[0] == 0 && effA(win[0]) != 255) c0 = bgColor;
    else c0 = layerPix[win[0]*32 +: 24];
    if (win[1] < 0) begin
      c1 = bgColor; a = 0;
    end else begin
      c1 = layerPix[win[1]*32 +: 24]; a = effA(win[1]);
    end
    for (int c = 0; c < 3; c++)
      r[c*8 +: 8] = 8'((a * int'(c1[c*8 +: 8]) + (255 - a) * int'(c0[c*8 +: 8]) + 127) / 255);
    return r;
  endfunction

  task automatic popCheck();
    logic [23:0] e;
    string t;
    e = expQ.pop_front();
    t = tagQ.pop_front();
    check(t, outRgb, e);
  endtask

  task automatic step(string tag, int x, int y);
    @(negedge clk);
    if (expQ.size() >= 2) popCheck();
    rasterX = CW'(x);
    rasterY = CW'(y);
    for (int l = 0; l < NL; l++) begin
      logic [7:0] a;
      a = opaque[l] ? 8'hFF : 8'((x * 29 + y * 53 + l * 71) & 255);
      layerPix[l*32 +: 32] = {a, 8'((x * 7 + l * 40) & 255), 8'((y * 19 + l * 90) & 255),
                              8'((x * y + l * 13) & 255)};
    end
    expQ.push_back(model(x, y));
    tagQ.push_back(tag);
  endtask

  task automatic drain();
    repeat (2) begin
      @(negedge clk);
      if (expQ.size() > 0) popCheck();
    end
  endtask

  task automatic sweep(string tag);
    for (int y = 0; y < 10; y++)
      for (int x = 0; x < 40; x++)
        step(tag, x, y);
    drain();
  endtask

  task automatic clearLayers();
    for (int l = 0; l < NL; l++) setLayer(l, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    defectMode = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    dispW = CW'(36);
    dispH = CW'(9);
    bgColor = 24'h204060;
    clearLayers();
    repeat (3) begin
      @(negedge clk);
      check("R1", outRgb, 24'h000000);  // R1 reset state
    end
    rstN = 1'b1;

    // R2: coverage edges and display border
    setLayer(0, 1, 0, 1, 3, 2, 10, 4, 0, 0, 1);
    setLayer(1, 1, 0, 2, 30, 5, 20, 10, 0, 0, 1);
    setLayer(2, 0, 0, 3, 0, 0, 40, 10, 0, 0, 1);
    sweep("R2");

    // R3: priority inside a pipe, with a tie
    clearLayers();
    setLayer(0, 1, 0, 1, 0, 0, 20, 8, 0, 0, 1);
    setLayer(1, 1, 0, 3, 5, 1, 12, 5, 0, 0, 1);
    setLayer(2, 1, 0, 3, 10, 3, 15, 6, 0, 0, 1);
    setLayer(3, 1, 1, 0, 0, 0, 0, 0, 1, 0, 1);
    sweep("R3");

    // R5/R8: per-pixel alpha blend across pipes
    clearLayers();
    setLayer(0, 1, 0, 0, 0, 0, 30, 9, 0, 0, 1);
    setLayer(1, 1, 1, 2, 8, 2, 25, 6, 0, 0, 0);
    setLayer(2, 1, 1, 1, 4, 0, 10, 9, 0, 0, 0);
    sweep("R5/R8");

    // R6: global alpha overrides pixel alpha
    setLayer(1, 1, 1, 2, 8, 2, 25, 6, 1, 8'h40, 0);
    setLayer(2, 1, 1, 1, 4, 0, 10, 9, 1, 8'hFF, 0);
    sweep("R6");

    // R4: pipe 0 empty, pipe 1 blends over background
    clearLayers();
    bgColor = 24'hC08010;
    setLayer(3, 1, 1, 2, 2, 1, 20, 7, 0, 0, 0);
    sweep("R4");

    // R7: defect on, translucent priority-0 winner on pipe 0
    clearLayers();
    setLayer(0, 1, 0, 0, 0, 0, 25, 9, 0, 0, 0);
    setLayer(1, 1, 0, 1, 15, 0, 10, 4, 0, 0, 0);
    setLayer(2, 1, 1, 2, 20, 3, 12, 5, 0, 0, 0);
    defectMode = 1'b1;
    sweep("R7");
    // R7: defect off keeps the same pixels
    defectMode = 1'b0;
    sweep("R7");
    // R7: defect on, opaque priority-0 winner is kept
    defectMode = 1'b1;
    opaque[0] = 1'b1;
    sweep("R7");
    // R7/R6: global alpha 255 counts as opaque
    opaque[0] = 1'b0;
    setLayer(0, 1, 0, 0, 0, 0, 25, 9, 1, 8'hFF, 0);
    sweep("R7");

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule